// File: doc/BRIEF.md
# Layered Decode Iteration Controller

This block sequences an iterative decoder that runs on a layered schedule. Each layer is one row of the base parity matrix, and its messages are updated as soon as that row is processed. The block walks the layers of an iteration in order. Every layer takes three cycles, and each cycle raises one strobe to the datapath: read, then compute, then write. After the last layer it spends one check cycle looking at the syndrome flag that an external checker provides. The block counts iterations against a limit that is programmed when the decode starts.

A decode stops when the programmed limit is reached. It also stops after any iteration whose syndrome is zero, but only while early termination is enabled. The block reports three results: whether the word converged, how many iterations were used, and the last syndrome weight. These results are held until the next start. A one-cycle done pulse marks the end of each decode.

Top module: `ldpc_layer_iter_ctl`

## Requirements
- R1: After a start is accepted, each layer index from 0 up to NUM_LAYERS-1 is visited in ascending order. Each layer spends exactly three cycles, with rd_phase_o, then comp_phase_o, then wr_phase_o high one at a time. layer_o shows the current layer index.
- R2: After the write cycle of the last layer there is one check cycle with no phase strobe. That cycle is followed either by the read cycle of layer 0 in the next iteration or by the done cycle.
- R3: max_iter_i is sampled when start is accepted. A value of 0 is treated as 1. The decode never runs more iterations than this effective limit.
- R4: With early_term_en_i high, a check cycle that sees synd_zero_i high ends the decode after that iteration. With early_term_en_i low, synd_zero_i does not change the number of iterations run.
- R5: start_i is accepted only while the block is idle. busy_o rises in the cycle after acceptance and stays high through the final check cycle. busy_o is low in the done cycle and in idle. A start raised while busy has no effect.
- R6: done_o is high for exactly one cycle after the final check. The block then returns to idle.
- R7: converged_o takes the value of synd_zero_i seen in the most recent check cycle, whether or not early termination is enabled. It is cleared when a start is accepted.
- R8: iter_used_o equals the number of iterations completed, including the iteration in which convergence was detected. It is updated in each check cycle and cleared when a start is accepted.
- R9: synd_weight_o holds the synd_weight_i value captured in the most recent check cycle.
- R10: After reset the block is idle. All strobes, busy_o, done_o and converged_o are 0, and layer_o, iter_used_o and synd_weight_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| max_iter_i | input | ITER_W | Iteration limit, where 0 means 1 |
| early_term_en_i | input | 1 | Enables the early stop on a zero syndrome |
| synd_zero_i | input | 1 | Syndrome is all zero, from the checker |
| synd_weight_i | input | WT_W | Syndrome weight, from the checker |
| rd_phase_o | output | 1 | Read phase strobe |
| comp_phase_o | output | 1 | Compute phase strobe |
| wr_phase_o | output | 1 | Write phase strobe |
| layer_o | output | LAYER_W | Current layer index |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | One-cycle end-of-decode pulse |
| converged_o | output | 1 | Zero syndrome seen at the last check |
| iter_used_o | output | ITER_W | Iterations completed |
| synd_weight_o | output | WT_W | Syndrome weight latched at the last check |

## Verification
The bench builds the block with its default parameters: seven layers, a 5-bit iteration field and an 8-bit weight. With these values the full-scale limit of 31 iterations can be reached in a short run, so the end of the count range is exercised. The limit of 30 is also exercised, in a run that stops early. Limits of 0 and 1 are run to cover the smallest decodes. The syndrome flag is made to assert at chosen iterations with early termination both on and off, which separates the converged report from the stop decision. A start pulse is also issued in the middle of a decode.

// File: rtl/ldpc_iter_pkg.sv
package ldpc_iter_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_COMP  = 3'd2,
    ST_WRITE = 3'd3,
    ST_CHECK = 3'd4,
    ST_DONE  = 3'd5
  } ctl_state_e;
endpackage

// File: rtl/ldpc_layer_ctr.sv
module ldpc_layer_ctr #(
  parameter int NUM_LAYERS = 7,
  localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  output logic [LAYER_W-1:0] layer_o,
  output logic               last_o
);
  localparam logic [LAYER_W-1:0] LastIdx = LAYER_W'(NUM_LAYERS - 1);

  logic [LAYER_W-1:0] layer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    layer_q <= '0;
    else if (clr_i) layer_q <= '0;
    else if (inc_i) layer_q <= layer_q + 1'b1;
  end

  assign layer_o = layer_q;
  assign last_o  = (layer_q == LastIdx);

  // R1
  layer_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    layer_q <= LastIdx);
endmodule

// File: rtl/ldpc_iter_ctr.sv
module ldpc_iter_ctr #(
  parameter int ITER_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ITER_W-1:0] lim_i,
  input  logic              inc_i,
  output logic [ITER_W-1:0] done_cnt_o,
  output logic              at_lim_o,
  output logic [ITER_W-1:0] lim_o
);
  logic [ITER_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= ITER_W'(1);
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= (lim_i == '0) ? ITER_W'(1) : lim_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // completed count once the current iteration's check is reached
  assign done_cnt_o = cnt_q + 1'b1;
  assign at_lim_o   = (done_cnt_o == lim_q);
  assign lim_o      = lim_q;

  // R3
  iter_below_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < lim_q) && (lim_q != '0));
endmodule

// File: rtl/ldpc_status_reg.sv
module ldpc_status_reg #(
  parameter int ITER_W = 5,
  parameter int WT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              zero_i,
  input  logic [WT_W-1:0]   weight_i,
  input  logic [ITER_W-1:0] used_i,
  output logic              conv_o,
  output logic [WT_W-1:0]   weight_o,
  output logic [ITER_W-1:0] used_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_o   <= 1'b0;
      weight_o <= '0;
      used_o   <= '0;
    end else if (clr_i) begin
      conv_o <= 1'b0;
      used_o <= '0;
    end else if (cap_i) begin
      conv_o   <= zero_i;
      weight_o <= weight_i;
      used_o   <= used_i;
    end
  end

  // R7
  conv_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !clr_i) |=> (conv_o == $past(zero_i)));
endmodule

// File: rtl/ldpc_sched_fsm.sv
module ldpc_sched_fsm
  import ldpc_iter_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       last_layer_i,
  input  logic       stop_i,
  output ctl_state_e state_o
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READ;
      ST_READ:  state_d = ST_COMP;
      ST_COMP:  state_d = ST_WRITE;
      ST_WRITE: state_d = last_layer_i ? ST_CHECK : ST_READ;
      ST_CHECK: state_d = stop_i ? ST_DONE : ST_READ;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R6
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/ldpc_layer_iter_ctl.sv
module ldpc_layer_iter_ctl
  import ldpc_iter_pkg::*;
#(
  parameter int NUM_LAYERS = 7,
  parameter int ITER_W     = 5,
  parameter int WT_W       = 8,
  localparam int LAYER_W = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ITER_W-1:0]  max_iter_i,
  input  logic               early_term_en_i,
  input  logic               synd_zero_i,
  input  logic [WT_W-1:0]    synd_weight_i,
  output logic               rd_phase_o,
  output logic               comp_phase_o,
  output logic               wr_phase_o,
  output logic [LAYER_W-1:0] layer_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               converged_o,
  output logic [ITER_W-1:0]  iter_used_o,
  output logic [WT_W-1:0]    synd_weight_o
);
  ctl_state_e        state;
  logic              accept, in_check, stop, last_layer, at_lim;
  logic [ITER_W-1:0] done_cnt, lim;

  assign accept   = (state == ST_IDLE) && start_i;
  assign in_check = (state == ST_CHECK);
  assign stop     = at_lim || (early_term_en_i && synd_zero_i);

  ldpc_sched_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .last_layer_i (last_layer),
    .stop_i       (stop),
    .state_o      (state)
  );

  ldpc_layer_ctr #(.NUM_LAYERS(NUM_LAYERS)) u_layer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept || (in_check && !stop)),
    .inc_i   ((state == ST_WRITE) && !last_layer),
    .layer_o (layer_o),
    .last_o  (last_layer)
  );

  ldpc_iter_ctr #(.ITER_W(ITER_W)) u_iter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .lim_i      (max_iter_i),
    .inc_i      (in_check && !stop),
    .done_cnt_o (done_cnt),
    .at_lim_o   (at_lim),
    .lim_o      (lim)
  );

  ldpc_status_reg #(.ITER_W(ITER_W), .WT_W(WT_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .cap_i    (in_check),
    .zero_i   (synd_zero_i),
    .weight_i (synd_weight_i),
    .used_i   (done_cnt),
    .conv_o   (converged_o),
    .weight_o (synd_weight_o),
    .used_o   (iter_used_o)
  );

  assign rd_phase_o   = (state == ST_READ);
  assign comp_phase_o = (state == ST_COMP);
  assign wr_phase_o   = (state == ST_WRITE);
  assign busy_o       = (state != ST_IDLE) && (state != ST_DONE);
  assign done_o       = (state == ST_DONE);

  // R1
  rd_then_comp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_phase_o |=> comp_phase_o);
  // R1
  comp_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_phase_o |=> wr_phase_o);
  // R2
  last_wr_to_check_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_phase_o && last_layer) |=> !(rd_phase_o || comp_phase_o || wr_phase_o) && busy_o);
  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R8
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_used_o <= lim);
endmodule

// File: tb/ldpc_layer_iter_ctl_tb_top.sv
module ldpc_layer_iter_ctl_tb_top;
  localparam int NL = 7;
  localparam int IW = 5;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] max_iter = '0;
  logic en = 1'b0;
  logic zero = 1'b0;
  logic [WW-1:0] weight = '0;
  logic rd, cp, wr, busy, done, conv;
  logic [2:0] layer;
  logic [IW-1:0] used;
  logic [WW-1:0] wt_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int zero_from = 1000;

  // reference model state: 0 idle,1 read,2 comp,3 write,4 check,5 done
  int m_st = 0, m_layer = 0, m_it = 0, m_lim = 1, m_used = 0, m_wt = 0;
  bit m_conv = 0;

  always #4 clk = ~clk;

  ldpc_layer_iter_ctl #(.NUM_LAYERS(NL), .ITER_W(IW), .WT_W(WW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .max_iter_i(max_iter),
    .early_term_en_i(en), .synd_zero_i(zero), .synd_weight_i(weight),
    .rd_phase_o(rd), .comp_phase_o(cp), .wr_phase_o(wr), .layer_o(layer),
    .busy_o(busy), .done_o(done), .converged_o(conv), .iter_used_o(used),
    .synd_weight_o(wt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_layer = 0; m_it = 0; m_lim = 1; m_used = 0; m_wt = 0; m_conv = 0;
    end else begin
      case (m_st)
        0: if (start) begin
             m_st = 1; m_layer = 0; m_it = 0; m_conv = 0; m_used = 0;
             m_lim = (max_iter == 0) ? 1 : int'(max_iter);
           end
        1: m_st = 2;
        2: m_st = 3;
        3: if (m_layer == NL - 1) m_st = 4; else begin m_layer++; m_st = 1; end
        4: begin
             m_conv = zero; m_wt = int'(weight); m_used = m_it + 1;
             if ((en && zero) || (m_it + 1 == m_lim)) m_st = 5;
             else begin m_it++; m_layer = 0; m_st = 1; end
           end
        default: m_st = 0;
      endcase
    end
  end

  // compare every cycle, then present syndrome inputs for the next check
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(rd == (m_st == 1), "R1 rd_phase", int'(rd), int'(m_st == 1));
      chk(cp == (m_st == 2), "R1 comp_phase", int'(cp), int'(m_st == 2));
      chk(wr == (m_st == 3), "R1 wr_phase", int'(wr), int'(m_st == 3));
      chk(int'(layer) == m_layer, "R1 layer", int'(layer), m_layer);
      chk(busy == (m_st >= 1 && m_st <= 4), "R5 busy", int'(busy), int'(m_st >= 1 && m_st <= 4));
      chk(done == (m_st == 5), "R6 done", int'(done), int'(m_st == 5));
      chk(conv == m_conv, "R7 converged", int'(conv), int'(m_conv));
      chk(int'(used) == m_used, "R8 iter_used", int'(used), m_used);
      chk(int'(wt_o) == m_wt, "R9 weight", int'(wt_o), m_wt);
    end
    zero   = (m_it + 1 >= zero_from);
    weight = zero ? '0 : WW'(60 - m_it);
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic decode(input int mi, input bit e, input int zf, input int stray_at,
                        input int exp_used, input bit exp_conv, input string tag);
    int n = 0;
    @(negedge clk);
    zero_from = zf; max_iter = IW'(mi); en = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      start = (n == stray_at);
    end
    start = 1'b0;
    chk(done, {tag, " done reached"}, int'(done), 1);
    chk(int'(used) == exp_used, {tag, " iterations"}, int'(used), exp_used);
    chk(conv == exp_conv, {tag, " converged"}, int'(conv), int'(exp_conv));
    @(negedge clk);
    chk(!busy && !done, "R6 back to idle", int'(busy || done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rd && !cp && !wr && !busy && !done && !conv, "R10 reset outputs", 0, 0);
    chk(layer == 0 && used == 0 && wt_o == 0, "R10 reset values", int'(used), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    decode(3, 1'b1, 1000, 0, 3, 1'b0, "R3 limit 3");
    decode(0, 1'b1, 1000, 0, 1, 1'b0, "R3 zero as one");
    decode(1, 1'b0, 1, 0, 1, 1'b1, "R3 limit 1");
    decode(30, 1'b1, 4, 0, 4, 1'b1, "R4 early stop");
    decode(5, 1'b0, 2, 0, 5, 1'b1, "R4 no early stop");
    decode(31, 1'b0, 1000, 40, 31, 1'b0, "R5 stray start, full scale");
    decode(2, 1'b1, 1, 0, 1, 1'b1, "R8 converge first");
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R6 stays idle", int'(busy), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule